// File: doc/BRIEF.md
# Serial Conversion Result Output Port

This block drives the 12-bit result of an analog-to-digital conversion out onto a single serial data line. A separate output-enable drives the tri-state buffer at the pin. A conversion sequencer strobes each finished result into the block. The host supplies the shift clock, and each falling edge of that clock steps the line to the next less significant bit.

The block also takes the converter's busy flag. While a conversion is running, the line's driver is forced off, whatever the read line is doing. When the busy flag drops, the newly strobed result replaces the old word and its most significant bit appears without any host action. An active-low read enable decides whether the driver may be switched on at all.

The external shift clock and busy flag are not related to the block clock. Both pass through two-stage synchronisers, and their edges are detected on a fast system clock. All timing is therefore accurate to the block clock cycle.

Top module: `ser_result_port`

## Requirements
- R1: The word leaves most significant bit first. Bit 11 comes first and bit 0 comes last on `sdo`.
- R2: Three block-clock rising edges after `busy_in` falls, `sdo` shows bit 11 of the result most recently strobed in, and the bit position restarts at bit 11.
- R3: Each falling edge of `sclk_in` seen while not busy advances `sdo` by exactly one bit, three block-clock edges later. A rising edge of `sclk_in` leaves `sdo` unchanged.
- R4: While `rd_n` is 1, `sdo_oe` is 0. The bit position still advances, so `sdo` keeps tracking the word.
- R5: While `busy_in` is 1, `sdo_oe` is 0 in the same cycle. It stays 0 until the new word has been loaded after `busy_in` falls.
- R6: Strobing `res_load` with a new `res_data`, during a conversion or outside one, does not change `sdo`. The previous word stays in place until `busy_in` falls.
- R7: After bit 0 has been reached, further falling edges of `sclk_in` keep bit 0 on `sdo`. The word does not wrap around.
- R8: Falling edges of `sclk_in` while busy are ignored. The first falling edge after a new word has loaded always moves `sdo` to bit 10.
- R9: During reset and after it, `sdo_oe` is 0, and the held word is all zeros, so `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_n | input | 1 | Read enable, active low; allows the output driver |
| sclk_in | input | 1 | Host shift clock, idles high; falling edges advance the data |
| busy_in | input | 1 | Converter busy flag, 1 while converting |
| res_data | input | 12 | Parallel conversion result |
| res_load | input | 1 | One-cycle strobe that captures `res_data` |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Enable for the tri-state data driver |

## Verification
The bench walks a full word out bit by bit, then pushes past bit 0. A port that wraps around would show bit 11 again, and one that reads past the end would show a stale zero. It toggles the shift clock during a conversion. A port that does not ignore those edges would start the new word at a lower bit. It strobes a result without any conversion ending. A port that loads on the strobe would change the line early. It raises the busy flag with read held low. An enable that is gated only through the synchroniser would leave the driver on for several cycles.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;
  // Width of one conversion result.
  localparam int unsigned RESULT_W = 12;

  // Synchronised view of one asynchronous control line.
  typedef struct packed {
    logic now;    // output of the last synchroniser stage
    logic level;  // one cycle behind 'now'; state used for gating
    logic fall;   // high-to-low seen between level and now
    logic rise;   // low-to-high seen between level and now
  } sync_sig_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/sig_sync.sv
module sig_sync
  import ser_out_pkg::*;
#(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      async_in,
  output sync_sig_t sig
);
  logic [STAGES-1:0] stage_q;
  logic              level_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RESET_VAL;
        else        stage_q[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RESET_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= RESET_VAL;
    else        level_q <= stage_q[STAGES-1];
  end

  always_comb begin
    sig.now   = stage_q[STAGES-1];
    sig.level = level_q;
    sig.fall  = level_q & ~stage_q[STAGES-1];
    sig.rise  = ~level_q & stage_q[STAGES-1];
  end
endmodule

// File: rtl/ser_word_shifter.sv
module ser_word_shifter #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_load,
  input  logic              load_go,
  input  logic              shift_go,
  output logic              msb
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] pend_q, pend_n;
  logic [DATA_W-1:0] word_q, word_n;
  logic [CNT_W-1:0]  pos_q, pos_n;
  logic              pend_en, word_en;

  // Next-state logic
  always_comb begin
    pend_en = res_load;
    pend_n  = res_data;
    word_en = 1'b0;
    word_n  = word_q;
    pos_n   = pos_q;
    if (load_go) begin
      word_en = 1'b1;
      word_n  = pend_q;
      pos_n   = '0;
    end else if (shift_go && (pos_q != LAST_POS)) begin
      word_en = 1'b1;
      word_n  = {word_q[DATA_W-2:0], 1'b0};
      pos_n   = pos_q + 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pos_q  <= '0;
    end else if (word_en) begin
      word_q <= word_n;
      pos_q  <= pos_n;
    end
  end

  assign msb = word_q[DATA_W-1];

  // R2: a load puts the strobed word in place
  p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (word_q == $past(pend_q)) && (pos_q == '0));

  // R7: the position saturates on the last bit
  p_hold_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == LAST_POS) && !load_go |=> (pos_q == LAST_POS) && $stable(word_q));

  // R6: without a load or a shift, the word is untouched
  p_word_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_go && !shift_go |=> $stable(word_q));

  // R3: a shift moves exactly one position
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_go && shift_go && (pos_q != LAST_POS) |=> pos_q == $past(pos_q) + 1'b1);
endmodule

// File: rtl/ser_result_port.sv
module ser_result_port
  import ser_out_pkg::*;
#(
  parameter int unsigned DATA_W      = RESULT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              sclk_in,
  input  logic              busy_in,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_load,
  output logic              sdo,
  output logic              sdo_oe
);
  logic      rst_ok;
  sync_sig_t sclk_s;
  sync_sig_t busy_s;
  logic      load_go;
  logic      shift_go;

  rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  // Shift clock idles high.
  sig_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sclk_sync (
    .clk      (clk),
    .rst_n    (rst_ok),
    .async_in (sclk_in),
    .sig      (sclk_s)
  );

  sig_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_busy_sync (
    .clk      (clk),
    .rst_n    (rst_ok),
    .async_in (busy_in),
    .sig      (busy_s)
  );

  always_comb begin
    load_go  = busy_s.fall;
    shift_go = sclk_s.fall & ~busy_s.level & ~busy_s.now;
  end

  ser_word_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk      (clk),
    .rst_n    (rst_ok),
    .res_data (res_data),
    .res_load (res_load),
    .load_go  (load_go),
    .shift_go (shift_go),
    .msb      (sdo)
  );

  // The raw busy flag kills the driver at once. The synchronised level holds it
  // off until the new word is loaded.
  assign sdo_oe = rst_ok & ~rd_n & ~busy_in & ~busy_s.level;

  // R5: the driver is never on while the synchronised busy state is set
  p_oe_off_busy_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    sdo_oe |-> !busy_s.level);

  // R8: shift-clock edges during a conversion never reach the shifter
  p_no_shift_busy_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    busy_s.level && sclk_s.fall |-> !shift_go);
endmodule

// File: tb/test_ser_result_port.sv
module test_ser_result_port;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n, rd_n, sclk_in, busy_in, res_load;
  logic [W-1:0] res_data;
  logic         sdo, sdo_oe;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic  oe;
    logic  d;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  ser_result_port i_ser_result_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_n     (rd_n),
    .sclk_in  (sclk_in),
    .busy_in  (busy_in),
    .res_data (res_data),
    .res_load (res_load),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

  // Driver side: push the expected item.
  task automatic expect_out(input logic oe, input logic d, input string tag);
    exp_t e;
    e.oe = oe; e.d = d; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor side: pop and compare against the ports.
  task automatic monitor_pop();
    exp_t e;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_checks++;
      if (sdo_oe !== e.oe || sdo !== e.d) begin
        n_fails++;
        $display("FAIL %s: got oe=%b d=%b, expected oe=%b d=%b",
                 e.tag, sdo_oe, sdo, e.oe, e.d);
      end
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One full shift-clock pulse.
  // R3: check after the fall, and again after the rise to show it had no effect.
  task automatic sclk_pulse(input logic oe, input logic d, input string tag);
    sclk_in = 1'b0;
    cyc(4);
    expect_out(oe, d, tag); monitor_pop();
    sclk_in = 1'b1;
    cyc(4);
    expect_out(oe, d, "R3 rise no effect"); monitor_pop();
  endtask

  task automatic strobe(input logic [W-1:0] v);
    res_data = v; res_load = 1'b1;
    cyc(1);
    res_load = 1'b0;
  endtask

  logic [W-1:0] va, vb;

  initial begin
    va = 12'hA5C;
    vb = 12'h3C6;
    rst_n = 1'b0; rd_n = 1'b1; sclk_in = 1'b1; busy_in = 1'b0;
    res_data = '0; res_load = 1'b0;
    cyc(3);
    expect_out(1'b0, 1'b0, "R9 in reset"); monitor_pop();
    rst_n = 1'b1;
    cyc(6);
    expect_out(1'b0, 1'b0, "R4 read high"); monitor_pop();
    rd_n = 1'b0;
    cyc(1);
    expect_out(1'b1, 1'b0, "R9 zero word after reset"); monitor_pop();

    // Conversion of va with read held low
    busy_in = 1'b1;
    #1;
    expect_out(1'b0, 1'b0, "R5 busy kills oe"); monitor_pop();
    cyc(1);
    strobe(va);
    sclk_in = 1'b0; cyc(4); sclk_in = 1'b1; cyc(4);   // R8 edges while busy
    sclk_in = 1'b0; cyc(4); sclk_in = 1'b1; cyc(4);
    expect_out(1'b0, 1'b0, "R6 old word kept while busy"); monitor_pop();
    busy_in = 1'b0;
    cyc(1);
    expect_out(1'b0, 1'b0, "R5 oe off until load"); monitor_pop();
    cyc(3);
    expect_out(1'b1, va[11], "R2 msb on busy fall"); monitor_pop();
    for (int i = W - 2; i >= 0; i--) begin
      sclk_pulse(1'b1, va[i], (i == W - 2) ? "R8 first fall gives bit 10" : "R1 order");
    end
    sclk_pulse(1'b1, va[0], "R7 hold bit 0");
    sclk_pulse(1'b1, va[0], "R7 hold bit 0 again");

    rd_n = 1'b1;
    #1;
    expect_out(1'b0, va[0], "R4 read high disables"); monitor_pop();
    cyc(1);
    strobe(vb);
    cyc(4);
    rd_n = 1'b0;
    cyc(1);
    expect_out(1'b1, va[0], "R6 strobe without conversion"); monitor_pop();

    // Conversion of vb with read high
    rd_n = 1'b1;
    busy_in = 1'b1;
    cyc(6);
    busy_in = 1'b0;
    cyc(4);
    expect_out(1'b0, vb[11], "R4 data tracks with oe off"); monitor_pop();
    sclk_pulse(1'b0, vb[10], "R4 shift with read high");
    rd_n = 1'b0;
    cyc(1);
    expect_out(1'b1, vb[10], "R2 second word visible"); monitor_pop();
    sclk_pulse(1'b1, vb[9], "R3 next bit");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    cyc(100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule